// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges the level-sensitive interrupt pins of a group of devices onto a small set of shared interrupt lines. Each device slot has four pins. Every pin is routed to one shared line by a fixed rule. Each line keeps an up/down counter of how many of its pins are currently asserted. A line is driven while its counter is nonzero, so the line acts as a wired-OR.

The block keeps the last level it saw on every pin. Only a real change of level moves a counter: a rise adds one and a fall subtracts one. Any number of pins may change in the same cycle, and every change is counted. The counter values are brought out next to the line levels so that the occupancy of each line can be observed. A parameter selects how pins map to lines: either the pin index is rotated by the device slot number, or the pin index is used directly.

Top module: `irq_share_agg`

## Requirements
- R1: Pin p of device slot d (p in 0..3) is bit d*4+p of `pin_lvl`; each pin level is 0 or 1.
- R2: When a pin presents the same level it presented in the previous cycle, no counter changes because of that pin.
- R3: A pin that changes from 0 to 1 adds one to its mapped line's counter, and a change from 1 to 0 subtracts one. The new count is visible on `line_cnt` after the first rising clock edge at which the new level is presented.
- R4: `line_out[l]` is 1 exactly when the counter of line l is nonzero, in the same cycle as that counter value.
- R5: With ROTATE_MAP=1, pin p of slot d drives line (p + d) mod NUM_LINES. With ROTATE_MAP=0, it drives line p mod NUM_LINES. Counter l occupies bits l*CNT_W+CNT_W-1 down to l*CNT_W of `line_cnt`.
- R6: While reset is asserted (rst_n low), all stored pin levels, counters and line outputs are zero.
- R7: Changes on several pins in the same cycle, including rises and falls that map to the same line, are all applied to the counters, and none of them is lost.
- R8: Counters are CNT_W = ceil(log2(NUM_DEV*4+1)) bits wide. With every pin high, each counter holds the exact number of pins mapped to it, without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_DEV*4 | Current level of every device interrupt pin |
| line_out | output | NUM_LINES | Shared interrupt line levels |
| line_cnt | output | NUM_LINES*CNT_W | Asserted-pin count of every shared line |

## Verification
On every cycle the assertions check that a line is high exactly when its count is nonzero, and that the counters do not move when no pin changed. They also check that the sum of all counters equals the number of stored pins that are high, and that no counter passes the total pin count. The routing rule cannot be shown by these invariants: only the bench scenarios can show it. The bench raises single pins in chosen slots, makes simultaneous rises and falls on the same line, and holds the levels, then compares every counter with a model of the mapping.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int PINS_PER_DEV = 4;

   // Shared line reached by pin p of slot d.
   function automatic int route_line(input int d, input int p, input int nlines, input bit rotate);
      if (rotate) return (p + d) % nlines;
      return p % nlines;
   endfunction
endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_lvl,
   output logic [NPINS-1:0] pin_q,
   output logic [NPINS-1:0] rise,
   output logic [NPINS-1:0] fall
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= pin_lvl;
   end

   assign rise = pin_lvl & ~pin_q;
   assign fall = ~pin_lvl & pin_q;
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
   import irq_agg_pkg::*;
#(
   parameter int NUM_DEV    = 8,
   parameter int NUM_LINES  = 4,
   parameter bit ROTATE_MAP = 1'b1,
   parameter int CNT_W      = 6,
   localparam int NPINS     = NUM_DEV * PINS_PER_DEV
) (
   input  logic [NPINS-1:0]           rise,
   input  logic [NPINS-1:0]           fall,
   output logic [NUM_LINES*CNT_W-1:0] inc,
   output logic [NUM_LINES*CNT_W-1:0] dec
);
   logic [NUM_LINES-1:0][NPINS-1:0] member;

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      for (genvar p = 0; p < PINS_PER_DEV; p++) begin : g_pin
         localparam int LN = route_line(d, p, NUM_LINES, ROTATE_MAP);
         for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
            assign member[l][d*PINS_PER_DEV+p] = (LN == l);
         end
      end
   end

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_sum
      assign inc[l*CNT_W +: CNT_W] = CNT_W'($countones(rise & member[l]));
      assign dec[l*CNT_W +: CNT_W] = CNT_W'($countones(fall & member[l]));
   end
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] inc,
   input  logic [CNT_W-1:0] dec,
   output logic [CNT_W-1:0] cnt,
   output logic             active
);
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt = cnt + inc - dec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else begin
         cnt    <= cnt_nxt;
         active <= (cnt_nxt != '0);
      end
   end
endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg
   import irq_agg_pkg::*;
#(
   parameter int NUM_DEV    = 8,
   parameter int NUM_LINES  = 4,
   parameter bit ROTATE_MAP = 1'b1,
   localparam int NPINS     = NUM_DEV * PINS_PER_DEV,
   localparam int CNT_W     = $clog2(NPINS + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NPINS-1:0]           pin_lvl,
   output logic [NUM_LINES-1:0]       line_out,
   output logic [NUM_LINES*CNT_W-1:0] line_cnt
);
   initial begin
      if (NUM_DEV < 1)   $error("NUM_DEV must be at least 1");
      if (NUM_LINES < 1) $error("NUM_LINES must be at least 1");
   end

   logic [NPINS-1:0]           pin_q, rise, fall;
   logic [NUM_LINES*CNT_W-1:0] inc, dec;

   irq_pin_tracker #(.NPINS(NPINS)) u_track (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl),
      .pin_q(pin_q), .rise(rise), .fall(fall)
   );

   irq_line_router #(
      .NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES),
      .ROTATE_MAP(ROTATE_MAP), .CNT_W(CNT_W)
   ) u_route (
      .rise(rise), .fall(fall), .inc(inc), .dec(dec)
   );

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_cnt
      irq_line_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n),
         .inc(inc[l*CNT_W +: CNT_W]), .dec(dec[l*CNT_W +: CNT_W]),
         .cnt(line_cnt[l*CNT_W +: CNT_W]), .active(line_out[l])
      );
   end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
   parameter int NUM_DEV   = 8,
   parameter int NUM_LINES = 4,
   parameter int NPINS     = 32,
   parameter int CNT_W     = 6
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NPINS-1:0]           pin_lvl,
   input logic [NPINS-1:0]           pin_q,
   input logic [NUM_LINES-1:0]       line_out,
   input logic [NUM_LINES*CNT_W-1:0] line_cnt
);
   int cnt_sum;
   always_comb begin
      cnt_sum = 0;
      for (int l = 0; l < NUM_LINES; l++) cnt_sum += int'(line_cnt[l*CNT_W +: CNT_W]);
   end

   // R2: unchanged pins leave every counter alone
   a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_lvl == pin_q) |=> $stable(line_cnt));

   // R3 / R7: all counted changes add up to the stored high pins
   a_r7_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_sum == $countones(pin_q));

   // R6: reset clears counters and lines
   a_r6_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (line_cnt == '0 && line_out == '0));

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_l
      // R4: line high exactly when count nonzero
      a_r4_line_level: assert property (@(posedge clk) disable iff (!rst_n)
         line_out[l] == (line_cnt[l*CNT_W +: CNT_W] != '0));
      // R8: counter stays within the pin total
      a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
         int'(line_cnt[l*CNT_W +: CNT_W]) <= NPINS);
   end
endmodule

bind irq_share_agg irq_agg_chk #(
   .NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES), .NPINS(NPINS), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_q(pin_q),
   .line_out(line_out), .line_cnt(line_cnt)
);

// File: tb/sim_irq_share_agg.sv
module sim_irq_share_agg;
   localparam int CLK_PERIOD = 10;
   localparam int ND = 8;
   localparam int NL = 4;
   localparam int NP = ND * 4;
   localparam int CW = $clog2(NP + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0] pin_lvl = '0;
   logic [NL-1:0] line_out;
   logic [NL*CW-1:0] line_cnt;
   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_share_agg #(.NUM_DEV(ND), .NUM_LINES(NL), .ROTATE_MAP(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl),
      .line_out(line_out), .line_cnt(line_cnt)
   );

   // R5 model: rotate pin index by slot
   function automatic int exp_cnt(input logic [NP-1:0] pins, input int l);
      int c = 0;
      for (int d = 0; d < ND; d++)
         for (int p = 0; p < 4; p++)
            if (pins[d*4+p] && ((p + d) % NL) == l) c++;
      return c;
   endfunction

   task automatic check_all(input string tag, input logic [NP-1:0] model);
      for (int l = 0; l < NL; l++) begin
         int e = exp_cnt(model, l);
         int a = int'(line_cnt[l*CW +: CW]);
         n_tests++;
         if (a != e) begin
            n_fail++;
            $display("FAIL %s line %0d count: actual %0d expected %0d", tag, l, a, e);
         end
         n_tests++;
         if (line_out[l] != (e != 0)) begin
            n_fail++;
            $display("FAIL %s/R4 line %0d level: actual %0b expected %0b", tag, l, line_out[l], e != 0);
         end
      end
   endtask

   // present levels, let one rising edge pass, check at the falling edge
   task automatic step(input logic [NP-1:0] v, input string tag);
      @(negedge clk);
      pin_lvl = v;
      @(negedge clk);
      check_all(tag, v);
   endtask

   initial begin
      logic [NP-1:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check_all("R6 reset", '0);
      rst_n = 1'b1;
      // R1/R5: pin 0 of slot 2 goes to line 2
      v = '0; v[2*4+0] = 1'b1;
      step(v, "R5 slot2 pin0");
      // R3: second pin on same line (slot 1 pin 1)
      v[1*4+1] = 1'b1;
      step(v, "R3 rise");
      // R2: hold levels several cycles
      repeat (3) step(v, "R2 hold");
      // R3: fall one of them
      v[2*4+0] = 1'b0;
      step(v, "R3 fall");
      // R7: simultaneous rise and fall on line 2 plus another rise
      v[1*4+1] = 1'b0; v[0*4+2] = 1'b1; v[7*4+3] = 1'b1;
      step(v, "R7 same-line mix");
      // R8: all pins high, each line holds ND
      v = '1;
      step(v, "R8 all high");
      step(v, "R2 all high hold");
      // R7: everything falls at once
      v = '0;
      step(v, "R7 all fall");
      // random mix
      for (int i = 0; i < 200; i++) begin
         v = $urandom() ^ (i[0] ? v : '0);
         step(v, "R3 random");
      end
      // R6: reset mid-run clears state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_all("R6 reset again", '0);
      rst_n = 1'b1;
      step(v, "R6 after reset");
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule